// File: doc/BRIEF.md
# Exception entry and priority controller

This block works next to a small processor core. Every cycle it looks at the exception sources (a reset request, data and prefetch abort flags, the fast and normal interrupt pins, which are active low, and the execute-stage decode flags for a software interrupt or an undefined instruction). It picks the one with the highest priority and carries out the hardware part of entering that exception.

On entry it copies the live status word into the saved-status slot of the target mode. It captures the return PC in that mode's link slot, switches the mode field and sets the interrupt-disable bits that belong to the exception type. It also presents a handler address to the fetch unit. A return pulse copies the saved status of the current mode back into the live status word.

The register file, the pipeline and the handler code stay outside. The core sees the live status, plus the saved status and link value of the current mode, through the output ports.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_n` is low the live status is supervisor mode with both disable bits set, `take_o` is 0 and `vector_o` is 0. Every saved-status slot holds user mode with both interrupts enabled (0x10), and every link slot holds 0.
- R2: Priority from high to low is: reset request, data abort, fast interrupt, normal interrupt, prefetch abort, then software interrupt or undefined instruction on one shared level.
- R3: A reset request is always taken, whatever the disable bits are. It enters supervisor mode (10011) and sets both disable bits.
- R4: A fast interrupt is taken only when `fiq_n_i` is low and the fast-disable bit is clear. Its entry goes to mode 10001 and sets both disable bits.
- R5: A normal interrupt is taken only when `irq_n_i` is low and the normal-disable bit is clear. Its entry goes to mode 10010, sets the normal-disable bit and leaves the fast-disable bit unchanged, so a second normal request stays pending.
- R6: A data abort or a prefetch abort enters abort mode (10111). It sets the normal-disable bit and leaves the fast-disable bit unchanged, so a fast interrupt can still preempt the abort handler.
- R7: A software interrupt enters supervisor mode (10011) and an undefined instruction enters undefined mode (11011). Both set the normal-disable bit and leave the fast-disable bit unchanged.
- R8: An entry taken on inputs sampled at clock edge k shows at the outputs after edge k. At that point the target mode's saved status holds the status word from before the entry, its link slot holds `exec_pc_i`, and `take_o` is high for exactly that one cycle.
- R9: Handler offsets are: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C. When `hivec_i` is high, 0xFFFF0000 is added to the offset. `vector_o` holds its value between entries.
- R10: An `eret_i` pulse copies the current mode's saved status into the live status in one cycle. In user (10000) or system (11111) mode it has no effect. If an exception is taken in the same cycle, the exception wins.
- R11: `spsr_o` packs a status word as bit 6 = normal-disable, bit 5 = fast-disable and bits 4:0 = mode. `spsr_o` and `lr_o` show the slots of the current mode, and read 0 in user or system mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| rst_req_i | input | 1 | Reset exception request |
| dabort_i | input | 1 | Data abort from the memory side |
| pabort_i | input | 1 | Prefetch abort, raised when the faulting instruction reaches execute |
| fiq_n_i | input | 1 | Fast interrupt pin, active low |
| irq_n_i | input | 1 | Normal interrupt pin, active low |
| swi_i | input | 1 | Software interrupt decoded in execute |
| undef_i | input | 1 | Undefined instruction decoded in execute |
| eret_i | input | 1 | Return-from-exception pulse |
| hivec_i | input | 1 | Selects the high handler base |
| exec_pc_i | input | AW | Return PC to capture on entry |
| take_o | output | 1 | One-cycle pulse when an entry has been performed |
| vector_o | output | AW | Handler address for the fetch unit |
| mode_o | output | 5 | Live mode field |
| irq_dis_o | output | 1 | Live normal-interrupt disable bit |
| fiq_dis_o | output | 1 | Live fast-interrupt disable bit |
| spsr_o | output | 7 | Saved status of the current mode |
| lr_o | output | AW | Link slot of the current mode |

## Verification
Every piece of state is registered, so a fault in the priority or masking logic shows at the ports one cycle after the stimulus. It appears as a wrong `mode_o`, wrong disable bits or a wrong `vector_o`. A fault in a saved-status or link slot can stay hidden until the controller returns into that mode. That is why the stimulus chains entries and returns: each bank is read back later through `spsr_o` and `lr_o`, and through the status that a return restores. The walk covers nested entry, masked repeats, same-cycle contention between sources and the collision between a return and an exception.

// File: rtl/exc_entry_pkg.sv
`timescale 1ns/1ps
package exc_entry_pkg;

    localparam int NUM_LEVELS = 6;
    localparam int NUM_BANKS  = 5;
    localparam int BANK_W     = $clog2(NUM_BANKS);

    localparam logic [4:0] MODE_USR = 5'b10000;
    localparam logic [4:0] MODE_FIQ = 5'b10001;
    localparam logic [4:0] MODE_IRQ = 5'b10010;
    localparam logic [4:0] MODE_SVC = 5'b10011;
    localparam logic [4:0] MODE_ABT = 5'b10111;
    localparam logic [4:0] MODE_UND = 5'b11011;
    localparam logic [4:0] MODE_SYS = 5'b11111;

    // arbitration levels, index 0 is the most urgent
    typedef enum logic [2:0] {
        LVL_RESET = 3'd0,
        LVL_DABT  = 3'd1,
        LVL_FIQ   = 3'd2,
        LVL_IRQ   = 3'd3,
        LVL_PABT  = 3'd4,
        LVL_INSN  = 3'd5
    } level_e;

    localparam logic [BANK_W-1:0] BANK_FIQ = 3'd0;
    localparam logic [BANK_W-1:0] BANK_IRQ = 3'd1;
    localparam logic [BANK_W-1:0] BANK_SVC = 3'd2;
    localparam logic [BANK_W-1:0] BANK_ABT = 3'd3;
    localparam logic [BANK_W-1:0] BANK_UND = 3'd4;

    localparam logic [7:0] OFS_RESET = 8'h00;
    localparam logic [7:0] OFS_UND   = 8'h04;
    localparam logic [7:0] OFS_SWI   = 8'h08;
    localparam logic [7:0] OFS_PABT  = 8'h0C;
    localparam logic [7:0] OFS_DABT  = 8'h10;
    localparam logic [7:0] OFS_IRQ   = 8'h18;
    localparam logic [7:0] OFS_FIQ   = 8'h1C;

    typedef struct packed {
        logic       irq_dis;
        logic       fiq_dis;
        logic [4:0] mode;
    } psr_t;

    localparam psr_t PSR_RESET     = '{irq_dis: 1'b1, fiq_dis: 1'b1, mode: MODE_SVC};
    localparam psr_t PSR_BANK_INIT = '{irq_dis: 1'b0, fiq_dis: 1'b0, mode: MODE_USR};

    typedef struct packed {
        logic              hit;
        logic [BANK_W-1:0] idx;
    } bank_sel_t;

    function automatic bank_sel_t bank_of_mode(input logic [4:0] m);
        bank_sel_t r;
        r.hit = 1'b1;
        r.idx = '0;
        case (m)
            MODE_FIQ: r.idx = BANK_FIQ;
            MODE_IRQ: r.idx = BANK_IRQ;
            MODE_SVC: r.idx = BANK_SVC;
            MODE_ABT: r.idx = BANK_ABT;
            MODE_UND: r.idx = BANK_UND;
            default:  r.hit = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/exc_prio_arb.sv
`timescale 1ns/1ps
module exc_prio_arb #(
    parameter int N = 6,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  gnt_o,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    logic [N-1:0] blocked;

    assign blocked[0] = 1'b0;
    genvar k;
    generate
        for (k = 1; k < N; k++) begin : g_chain
            assign blocked[k] = blocked[k-1] | req_i[k-1];
        end
    endgenerate

    assign gnt_o = req_i & ~blocked;
    assign any_o = |req_i;

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (gnt_o[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/exc_target_dec.sv
`timescale 1ns/1ps
module exc_target_dec
    import exc_entry_pkg::*;
#(
    parameter int AW = 32,
    parameter logic [AW-1:0] HI_BASE = AW'(32'hFFFF_0000)
) (
    input  level_e            lvl_i,
    input  logic              insn_swi_i,
    input  logic              hivec_i,
    output logic [4:0]        mode_o,
    output logic [BANK_W-1:0] bank_o,
    output logic              mask_fiq_o,
    output logic [AW-1:0]     vec_o
);
    logic [7:0] ofs;

    always_comb begin
        mask_fiq_o = 1'b0;
        mode_o     = MODE_SVC;
        bank_o     = BANK_SVC;
        ofs        = OFS_RESET;
        case (lvl_i)
            LVL_RESET: begin
                mask_fiq_o = 1'b1;
            end
            LVL_DABT: begin
                mode_o = MODE_ABT;
                bank_o = BANK_ABT;
                ofs    = OFS_DABT;
            end
            LVL_FIQ: begin
                mode_o     = MODE_FIQ;
                bank_o     = BANK_FIQ;
                ofs        = OFS_FIQ;
                mask_fiq_o = 1'b1;
            end
            LVL_IRQ: begin
                mode_o = MODE_IRQ;
                bank_o = BANK_IRQ;
                ofs    = OFS_IRQ;
            end
            LVL_PABT: begin
                mode_o = MODE_ABT;
                bank_o = BANK_ABT;
                ofs    = OFS_PABT;
            end
            default: begin
                if (insn_swi_i) begin
                    ofs = OFS_SWI;
                end else begin
                    mode_o = MODE_UND;
                    bank_o = BANK_UND;
                    ofs    = OFS_UND;
                end
            end
        endcase
    end

    assign vec_o = (hivec_i ? HI_BASE : '0) | AW'(ofs);
endmodule

// File: rtl/exc_entry_ctrl.sv
`timescale 1ns/1ps
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int AW = 32,
    parameter logic [AW-1:0] HI_BASE = AW'(32'hFFFF_0000)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rst_req_i,
    input  logic          dabort_i,
    input  logic          pabort_i,
    input  logic          fiq_n_i,
    input  logic          irq_n_i,
    input  logic          swi_i,
    input  logic          undef_i,
    input  logic          eret_i,
    input  logic          hivec_i,
    input  logic [AW-1:0] exec_pc_i,
    output logic          take_o,
    output logic [AW-1:0] vector_o,
    output logic [4:0]    mode_o,
    output logic          irq_dis_o,
    output logic          fiq_dis_o,
    output logic [6:0]    spsr_o,
    output logic [AW-1:0] lr_o
);
    localparam int LW = $clog2(NUM_LEVELS);

    typedef struct packed {
        psr_t                          cpsr;
        psr_t [NUM_BANKS-1:0]          spsr;
        logic [NUM_BANKS-1:0][AW-1:0]  lr;
        logic [AW-1:0]                 vec;
        logic                          take;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_LEVELS-1:0] req;
    logic [NUM_LEVELS-1:0] gnt;
    logic                  any_req;
    logic [LW-1:0]         lvl_idx;
    logic [4:0]            tgt_mode;
    logic [BANK_W-1:0]     tgt_bank;
    logic                  tgt_mask_fiq;
    logic [AW-1:0]         tgt_vec;
    bank_sel_t             cur_bank;

    always_comb begin
        req[LVL_RESET] = rst_req_i;
        req[LVL_DABT]  = dabort_i;
        req[LVL_FIQ]   = ~fiq_n_i & ~st_q.cpsr.fiq_dis;
        req[LVL_IRQ]   = ~irq_n_i & ~st_q.cpsr.irq_dis;
        req[LVL_PABT]  = pabort_i;
        req[LVL_INSN]  = swi_i | undef_i;
    end

    exc_prio_arb #(.N(NUM_LEVELS)) u_arb (
        .req_i (req),
        .gnt_o (gnt),
        .any_o (any_req),
        .idx_o (lvl_idx)
    );

    exc_target_dec #(.AW(AW), .HI_BASE(HI_BASE)) u_dec (
        .lvl_i      (level_e'(lvl_idx)),
        .insn_swi_i (swi_i),
        .hivec_i    (hivec_i),
        .mode_o     (tgt_mode),
        .bank_o     (tgt_bank),
        .mask_fiq_o (tgt_mask_fiq),
        .vec_o      (tgt_vec)
    );

    assign cur_bank = bank_of_mode(st_q.cpsr.mode);

    always_comb begin
        st_d      = st_q;
        st_d.take = 1'b0;
        if (any_req) begin
            st_d.spsr[tgt_bank]  = st_q.cpsr;
            st_d.lr[tgt_bank]    = exec_pc_i;
            st_d.cpsr.mode       = tgt_mode;
            st_d.cpsr.irq_dis    = 1'b1;
            if (tgt_mask_fiq) begin
                st_d.cpsr.fiq_dis = 1'b1;
            end
            st_d.vec  = tgt_vec;
            st_d.take = 1'b1;
        end else if (eret_i && cur_bank.hit) begin
            st_d.cpsr = st_q.spsr[cur_bank.idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cpsr <= PSR_RESET;
            st_q.spsr <= {NUM_BANKS{PSR_BANK_INIT}};
            st_q.lr   <= '0;
            st_q.vec  <= '0;
            st_q.take <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign take_o    = st_q.take;
    assign vector_o  = st_q.vec;
    assign mode_o    = st_q.cpsr.mode;
    assign irq_dis_o = st_q.cpsr.irq_dis;
    assign fiq_dis_o = st_q.cpsr.fiq_dis;
    assign spsr_o    = cur_bank.hit ? st_q.spsr[cur_bank.idx] : '0;
    assign lr_o      = cur_bank.hit ? st_q.lr[cur_bank.idx]   : '0;
endmodule

// File: rtl/exc_entry_chk.sv
`timescale 1ns/1ps
module exc_entry_chk
    import exc_entry_pkg::*;
#(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rst_req_i,
    input logic          dabort_i,
    input logic          pabort_i,
    input logic          fiq_n_i,
    input logic          irq_n_i,
    input logic          swi_i,
    input logic          undef_i,
    input logic          eret_i,
    input logic          hivec_i,
    input logic [AW-1:0] exec_pc_i,
    input logic          take_o,
    input logic [AW-1:0] vector_o,
    input logic [4:0]    mode_o,
    input logic          irq_dis_o,
    input logic          fiq_dis_o,
    input logic [6:0]    spsr_o,
    input logic [AW-1:0] lr_o
);
    p_reset_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_i |=> take_o && mode_o == MODE_SVC && irq_dis_o && fiq_dis_o);

    p_fiq_masks_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fiq_n_i && !fiq_dis_o && !rst_req_i && !dabort_i)
        |=> take_o && mode_o == MODE_FIQ && irq_dis_o && fiq_dis_o);

    p_irq_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_dis_o && (fiq_n_i || fiq_dis_o) && !rst_req_i && !dabort_i &&
         !pabort_i && !swi_i && !undef_i) |=> !take_o);

    p_abort_keeps_fiq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dabort_i && !rst_req_i)
        |=> take_o && mode_o == MODE_ABT && fiq_dis_o == $past(fiq_dis_o));

    p_link_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> lr_o == $past(exec_pc_i));

    p_vector_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> vector_o[1:0] == 2'b00);

    p_vector_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> $stable(vector_o) || $past(!rst_n));
endmodule

bind exc_entry_ctrl exc_entry_chk #(.AW(AW)) u_chk (.*);

// File: tb/exc_entry_ctrl_test.sv
`timescale 1ns/1ps
module exc_entry_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rst_req_i = 1'b0, dabort_i = 1'b0, pabort_i = 1'b0;
    logic        fiq_n_i = 1'b1, irq_n_i = 1'b1, swi_i = 1'b0, undef_i = 1'b0;
    logic        eret_i = 1'b0, hivec_i = 1'b0;
    logic [31:0] exec_pc_i = '0;
    logic        take_o;
    logic [31:0] vector_o;
    logic [4:0]  mode_o;
    logic        irq_dis_o, fiq_dis_o;
    logic [6:0]  spsr_o;
    logic [31:0] lr_o;

    always #2.5 clk = ~clk;

    exc_entry_ctrl uut (
        .clk, .rst_n, .rst_req_i, .dabort_i, .pabort_i, .fiq_n_i, .irq_n_i,
        .swi_i, .undef_i, .eret_i, .hivec_i, .exec_pc_i,
        .take_o, .vector_o, .mode_o, .irq_dis_o, .fiq_dis_o, .spsr_o, .lr_o
    );

    localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                           SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011;

    typedef struct packed {
        logic        rst, dab, pab, fn, in, swi, und, ret, hiv;
        logic [31:0] pc;
        logic        take;
        logic [31:0] vec;
        logic [4:0]  mode;
        logic        idis, fdis;
        logic [6:0]  spsr;
        logic [31:0] lr;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VT [NV] = '{
        // R10: return from supervisor to user, interrupts enabled
        '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0, 32'h0,   1'b0,32'h0,       USR,1'b0,1'b0,7'h00,32'h0,   4'd10},
        // R5: normal interrupt entry
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h100, 1'b1,32'h18,      IRQ,1'b1,1'b0,7'h10,32'h100, 4'd5},
        // R5: second normal request blocked
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h104, 1'b0,32'h18,      IRQ,1'b1,1'b0,7'h10,32'h100, 4'd5},
        // R4: fast interrupt preempts, masks both
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h200, 1'b1,32'h1C,      FIQ,1'b1,1'b1,7'h52,32'h200, 4'd4},
        // R4: second fast request blocked
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 32'h204, 1'b0,32'h1C,      FIQ,1'b1,1'b1,7'h52,32'h200, 4'd4},
        // R10: back to normal-interrupt handler
        '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0, 32'h0,   1'b0,32'h1C,      IRQ,1'b1,1'b0,7'h10,32'h100, 4'd10},
        // R10: back to user
        '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0, 32'h0,   1'b0,32'h1C,      USR,1'b0,1'b0,7'h00,32'h0,   4'd10},
        // R2: data abort beats fast and normal interrupts
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h300, 1'b1,32'h10,      ABT,1'b1,1'b0,7'h10,32'h300, 4'd2},
        // R6: fast interrupt still taken inside abort handler
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 32'h304, 1'b1,32'h1C,      FIQ,1'b1,1'b1,7'h57,32'h304, 4'd6},
        // R10 / R11: return to abort mode, bank visible
        '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0, 32'h0,   1'b0,32'h1C,      ABT,1'b1,1'b0,7'h10,32'h300, 4'd11},
        // R10: back to user
        '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0, 32'h0,   1'b0,32'h1C,      USR,1'b0,1'b0,7'h00,32'h0,   4'd10},
        // R2: normal interrupt beats prefetch abort and software interrupt
        '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 32'h400, 1'b1,32'h18,      IRQ,1'b1,1'b0,7'h10,32'h400, 4'd2},
        // R6: prefetch abort beats software interrupt
        '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 32'h404, 1'b1,32'h0C,      ABT,1'b1,1'b0,7'h52,32'h404, 4'd6},
        // R9 / R7: software interrupt, high base
        '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1, 32'h408, 1'b1,32'hFFFF0008,SVC,1'b1,1'b0,7'h57,32'h408, 4'd9},
        // R7: undefined instruction
        '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 32'h40C, 1'b1,32'h04,      UND,1'b1,1'b0,7'h53,32'h40C, 4'd7},
        // R10: return to supervisor
        '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0, 32'h0,   1'b0,32'h04,      SVC,1'b1,1'b0,7'h57,32'h408, 4'd10},
        // R10: exception wins over return in the same cycle
        '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0, 32'h500, 1'b1,32'h10,      ABT,1'b1,1'b0,7'h53,32'h500, 4'd10},
        // R3: reset request beats everything
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 32'h600, 1'b1,32'h00,      SVC,1'b1,1'b1,7'h57,32'h600, 4'd3},
        // R3 / R9: reset request with masks set, high base
        '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 32'h604, 1'b1,32'hFFFF0000,SVC,1'b1,1'b1,7'h73,32'h604, 4'd3},
        // R8: take is a single-cycle pulse, vector holds
        '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 32'h0,   1'b0,32'hFFFF0000,SVC,1'b1,1'b1,7'h73,32'h604, 4'd8}
    };

    int applied = 0;
    int errors  = 0;
    bit done    = 1'b0;

    task automatic drive(input vec_t v);
        rst_req_i = v.rst; dabort_i = v.dab; pabort_i = v.pab;
        fiq_n_i = v.fn; irq_n_i = v.in; swi_i = v.swi; undef_i = v.und;
        eret_i = v.ret; hivec_i = v.hiv; exec_pc_i = v.pc;
    endtask

    task automatic idle();
        rst_req_i = 1'b0; dabort_i = 1'b0; pabort_i = 1'b0;
        fiq_n_i = 1'b1; irq_n_i = 1'b1; swi_i = 1'b0; undef_i = 1'b0;
        eret_i = 1'b0; hivec_i = 1'b0; exec_pc_i = '0;
    endtask

    task automatic compare(input string tag, input vec_t e);
        applied++;
        if (take_o !== e.take || vector_o !== e.vec || mode_o !== e.mode ||
            irq_dis_o !== e.idis || fiq_dis_o !== e.fdis ||
            spsr_o !== e.spsr || lr_o !== e.lr) begin
            errors++;
            $display("FAIL %s: got take=%b vec=%h mode=%b I=%b F=%b spsr=%h lr=%h, expected take=%b vec=%h mode=%b I=%b F=%b spsr=%h lr=%h",
                     tag, take_o, vector_o, mode_o, irq_dis_o, fiq_dis_o, spsr_o, lr_o,
                     e.take, e.vec, e.mode, e.idis, e.fdis, e.spsr, e.lr);
        end
    endtask

    function automatic vec_t expect_state(input logic take, input logic [31:0] vec,
                                          input logic [4:0] mode, input logic idis,
                                          input logic fdis, input logic [6:0] spsr,
                                          input logic [31:0] lr);
        vec_t e = '0;
        e.take = take; e.vec = vec; e.mode = mode; e.idis = idis;
        e.fdis = fdis; e.spsr = spsr; e.lr = lr;
        return e;
    endfunction

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state while rst_n low and just after release
        compare("R1 reset held", expect_state(1'b0, 32'h0, SVC, 1'b1, 1'b1, 7'h10, 32'h0));
        rst_n = 1'b1;
        @(posedge clk); #1;
        compare("R1 after release", expect_state(1'b0, 32'h0, SVC, 1'b1, 1'b1, 7'h10, 32'h0));

        for (int i = 0; i < NV; i++) begin
            drive(VT[i]);
            @(posedge clk); #1;
            compare($sformatf("R%0d vector %0d", VT[i].rq, i), VT[i]);
        end
        idle();

        // R1: hardware reset in mid-run clears every bank
        rst_n = 1'b0;
        #2;
        compare("R1 mid-run reset", expect_state(1'b0, 32'h0, SVC, 1'b1, 1'b1, 7'h10, 32'h0));
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R10: return from supervisor restores the initial user status
        eret_i = 1'b1;
        @(posedge clk); #1;
        compare("R10 return to user", expect_state(1'b0, 32'h0, USR, 1'b0, 1'b0, 7'h00, 32'h0));
        // R10: return in user mode is ignored
        @(posedge clk); #1;
        compare("R10 return ignored in user", expect_state(1'b0, 32'h0, USR, 1'b0, 1'b0, 7'h00, 32'h0));
        eret_i = 1'b0;

        // R7 / R8: undefined instruction from user, then a quiet cycle
        undef_i = 1'b1; exec_pc_i = 32'h700;
        @(posedge clk); #1;
        compare("R7 undefined from user", expect_state(1'b1, 32'h04, UND, 1'b1, 1'b0, 7'h10, 32'h700));
        idle();
        @(posedge clk); #1;
        compare("R8 pulse ends", expect_state(1'b0, 32'h04, UND, 1'b1, 1'b0, 7'h10, 32'h700));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
            $finish;
        end
    end

endmodule